// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block switches a flat display panel on and off in a fixed order with programmed waits. It drives three enables: panel supply, data link and backlight. It counts every wait against a time base of about 100 microseconds. That time base is a clock-enable pulse divided down from the reference clock. A level request input asks for the panel to be on or off. A registered status output reports which phase the sequencer is in.

Software programs the block through a simple write-only port. Two delay words each carry a pair of 16-bit delays. A divisor word holds the reference divide count in its upper bits and a 5-bit power-cycle field in its low bits. The power-cycle field is coarse, counted in units of `CYC_UNIT_TICKS` time-base ticks. It holds the required number of units plus one. After each power-down the block holds off any new power-up until that guard time has run out. A dedicated write address updates only the power-cycle field, so software can change it without read-modify-write.

Top module: `pnl_seq_top`

## Requirements
- R1: After reset all three enables are low and the status is 0 (off).
- R2: Address 0 holds the power-on word. Bits 31:16 are the supply-to-link delay and bits 15:0 are the link-to-backlight delay. Both are counted in time-base ticks.
- R3: Address 1 holds the power-off word. Bits 31:16 are the link-off-to-supply-off delay and bits 15:0 are the backlight-off-to-link-off delay. Both are counted in ticks.
- R4: When the request goes high in the off state, the order is: supply enable rises first, then link enable after the bits 31:16 delay of address 0, then backlight enable after the bits 15:0 delay of address 0.
- R5: When the request goes low in the on state, the order is: backlight enable falls first, then link enable after the bits 15:0 delay of address 1, then supply enable after the bits 31:16 delay of address 1.
- R6: Address 2 bits 4:0 hold the guard value v. Once the supply falls, the status is 4 and a new power-up waits (v-1)*CYC_UNIT_TICKS ticks. A v of 0 or 1 gives no wait.
- R7: A write to address 3 changes only bits 4:0 of the divisor word and leaves bits 31:5 as they were.
- R8: If the request goes low while powering up, the block turns to power-down (status 3) at once. Any enable not yet raised stays low.
- R9: A request going high during power-down has no effect until the power-down and the guard time have both finished.
- R10: The status encoding is: 0 off, 1 powering up, 2 on, 3 powering down, 4 guard wait.
- R11: Backlight enable high implies link enable high, and link enable high implies supply enable high.
- R12: Address 2 bits 31:8 give the number of reference clocks per tick. A value of 0 gives a tick on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | reference clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 2 | register address (0 on word, 1 off word, 2 divisor, 3 guard field only) |
| wr_data | input | 32 | register write data |
| pwr_req | input | 1 | 1 requests panel on, 0 requests off |
| vdd_en | output | 1 | panel supply enable |
| link_en | output | 1 | data link enable |
| bl_en | output | 1 | backlight enable |
| seq_status | output | 3 | sequencer phase (R10 encoding) |

## Verification
The hardest cases to reach are the two aborts and the ignored request. Each needs the request to change while the sequencer sits in one particular intermediate phase. The stimulus programs one delay far longer than the other, so that phase lasts many ticks. It then waits for the enable edge that marks entry into that phase and toggles the request two clocks later. The guard-field-only write is checked indirectly: the upper bits of its data are set so that, if they leaked into the register, the divide count would become huge and the next delay measurement would run out of time.

// File: rtl/pnl_seq_pkg.sv
package pnl_seq_pkg;
  // externally visible phase code
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RAMP_UP = 3'd1,
    ST_ACTIVE  = 3'd2,
    ST_RAMP_DN = 3'd3,
    ST_GUARD   = 3'd4
  } pnl_status_e;

  // internal sequencer steps
  typedef enum logic [2:0] {
    SQ_OFF     = 3'd0,
    SQ_UP_VDD  = 3'd1,
    SQ_UP_LINK = 3'd2,
    SQ_ON      = 3'd3,
    SQ_DN_BL   = 3'd4,
    SQ_DN_LINK = 3'd5,
    SQ_CYCLE   = 3'd6
  } pnl_step_e;

  localparam logic [1:0] A_ON_WORD  = 2'd0;
  localparam logic [1:0] A_OFF_WORD = 2'd1;
  localparam logic [1:0] A_DIV_WORD = 2'd2;
  localparam logic [1:0] A_CYC_ONLY = 2'd3;
endpackage

// File: rtl/pnl_tick_gen.sv
module pnl_tick_gen #(
  parameter int DIV_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] ref_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  assign last = (ref_div == '0) ? '0 : ref_div - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= last) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/pnl_delay_regs.sv
module pnl_delay_regs
  import pnl_seq_pkg::*;
#(
  parameter int DLY_W       = 16,
  parameter int CYC_W       = 5,
  parameter int DIV_W       = 24,
  parameter int REF_DIV_RST = 2400
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  output logic [DLY_W-1:0] dly_up,
  output logic [DLY_W-1:0] dly_blon,
  output logic [DLY_W-1:0] dly_dn,
  output logic [DLY_W-1:0] dly_bloff,
  output logic [CYC_W-1:0] cyc_val,
  output logic [DIV_W-1:0] ref_div
);
  localparam logic [31:0] DIV_RST = 32'(REF_DIV_RST) << 8;

  logic [31:0] on_word, off_word, div_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_word  <= '0;
      off_word <= '0;
      div_word <= DIV_RST;
    end else if (wr_en) begin
      case (wr_addr)
        A_ON_WORD:  on_word  <= wr_data;
        A_OFF_WORD: off_word <= wr_data;
        A_DIV_WORD: div_word <= wr_data;
        default:    div_word[CYC_W-1:0] <= wr_data[CYC_W-1:0];
      endcase
    end
  end

  assign dly_up    = on_word[16 +: DLY_W];
  assign dly_blon  = on_word[0 +: DLY_W];
  assign dly_dn    = off_word[16 +: DLY_W];
  assign dly_bloff = off_word[0 +: DLY_W];
  assign cyc_val   = div_word[CYC_W-1:0];
  assign ref_div   = div_word[8 +: DIV_W];
endmodule

// File: rtl/pnl_cycle_guard.sv
module pnl_cycle_guard #(
  parameter int CYC_W          = 5,
  parameter int CYC_UNIT_TICKS = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CYC_W-1:0] cyc_val,
  output logic             done
);
  localparam int GW = CYC_W + $clog2(CYC_UNIT_TICKS + 1);

  logic [GW-1:0] remain;
  logic [GW-1:0] total;
  logic [CYC_W-1:0] units;

  // field carries one extra unit
  assign units = (cyc_val == '0) ? '0 : cyc_val - 1'b1;
  assign total = GW'(units) * GW'(CYC_UNIT_TICKS);
  assign done  = (remain == '0);

  always_ff @(posedge clk) begin
    if (rst)
      remain <= '0;
    else if (load)
      remain <= total;
    else if (tick && !done)
      remain <= remain - 1'b1;
  end
endmodule

// File: rtl/pnl_seq_fsm.sv
module pnl_seq_fsm
  import pnl_seq_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             pwr_req,
  input  logic [DLY_W-1:0] dly_up,
  input  logic [DLY_W-1:0] dly_blon,
  input  logic [DLY_W-1:0] dly_dn,
  input  logic [DLY_W-1:0] dly_bloff,
  input  logic             guard_done,
  output logic             guard_load,
  output logic             vdd_en,
  output logic             link_en,
  output logic             bl_en,
  output logic [2:0]       status
);
  pnl_step_e st, nxt;
  logic [DLY_W-1:0] cnt, cnt_load;
  logic expired;

  assign expired = (cnt == '0);

  always_comb begin
    nxt = st;
    case (st)
      SQ_OFF:     if (pwr_req) nxt = SQ_UP_VDD;
      SQ_UP_VDD:  if (!pwr_req) nxt = SQ_DN_LINK;
                  else if (expired) nxt = SQ_UP_LINK;
      SQ_UP_LINK: if (!pwr_req) nxt = SQ_DN_BL;
                  else if (expired) nxt = SQ_ON;
      SQ_ON:      if (!pwr_req) nxt = SQ_DN_BL;
      SQ_DN_BL:   if (expired) nxt = SQ_DN_LINK;
      SQ_DN_LINK: if (expired) nxt = SQ_CYCLE;
      SQ_CYCLE:   if (guard_done) nxt = SQ_OFF;
      default:    nxt = SQ_OFF;
    endcase
  end

  always_comb begin
    case (nxt)
      SQ_UP_VDD:  cnt_load = dly_up;
      SQ_UP_LINK: cnt_load = dly_blon;
      SQ_DN_BL:   cnt_load = dly_bloff;
      SQ_DN_LINK: cnt_load = dly_dn;
      default:    cnt_load = '0;
    endcase
  end

  assign guard_load = (st == SQ_DN_LINK) && (nxt == SQ_CYCLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_OFF;
      cnt     <= '0;
      vdd_en  <= 1'b0;
      link_en <= 1'b0;
      bl_en   <= 1'b0;
      status  <= ST_IDLE;
    end else begin
      st <= nxt;
      if (nxt != st)
        cnt <= cnt_load;
      else if (tick && !expired)
        cnt <= cnt - 1'b1;
      vdd_en  <= (nxt != SQ_OFF) && (nxt != SQ_CYCLE);
      link_en <= (nxt == SQ_UP_LINK) || (nxt == SQ_ON) || (nxt == SQ_DN_BL);
      bl_en   <= (nxt == SQ_ON);
      case (nxt)
        SQ_UP_VDD, SQ_UP_LINK: status <= ST_RAMP_UP;
        SQ_ON:                 status <= ST_ACTIVE;
        SQ_DN_BL, SQ_DN_LINK:  status <= ST_RAMP_DN;
        SQ_CYCLE:              status <= ST_GUARD;
        default:               status <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pnl_seq_top.sv
module pnl_seq_top #(
  parameter int DLY_W          = 16,
  parameter int CYC_W          = 5,
  parameter int DIV_W          = 24,
  parameter int REF_DIV_RST    = 2400,
  parameter int CYC_UNIT_TICKS = 1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        pwr_req,
  output logic        vdd_en,
  output logic        link_en,
  output logic        bl_en,
  output logic [2:0]  seq_status
);
  logic [DLY_W-1:0] dly_up, dly_blon, dly_dn, dly_bloff;
  logic [CYC_W-1:0] cyc_val;
  logic [DIV_W-1:0] ref_div;
  logic tick, guard_load, guard_done;

  pnl_delay_regs #(
    .DLY_W(DLY_W), .CYC_W(CYC_W), .DIV_W(DIV_W), .REF_DIV_RST(REF_DIV_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dly_up(dly_up), .dly_blon(dly_blon), .dly_dn(dly_dn), .dly_bloff(dly_bloff),
    .cyc_val(cyc_val), .ref_div(ref_div)
  );

  pnl_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .ref_div(ref_div), .tick(tick)
  );

  pnl_cycle_guard #(.CYC_W(CYC_W), .CYC_UNIT_TICKS(CYC_UNIT_TICKS)) u_guard (
    .clk(clk), .rst(rst), .tick(tick), .load(guard_load), .cyc_val(cyc_val),
    .done(guard_done)
  );

  pnl_seq_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk(clk), .rst(rst), .tick(tick), .pwr_req(pwr_req),
    .dly_up(dly_up), .dly_blon(dly_blon), .dly_dn(dly_dn), .dly_bloff(dly_bloff),
    .guard_done(guard_done), .guard_load(guard_load),
    .vdd_en(vdd_en), .link_en(link_en), .bl_en(bl_en), .status(seq_status)
  );
endmodule

// File: rtl/pnl_seq_chk.sv
module pnl_seq_chk
  import pnl_seq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       pwr_req,
  input logic       vdd_en,
  input logic       link_en,
  input logic       bl_en,
  input logic [2:0] seq_status
);
  p_bl_link_r11: assert property (@(posedge clk) disable iff (rst)
    bl_en |-> link_en);
  p_link_vdd_r11: assert property (@(posedge clk) disable iff (rst)
    link_en |-> vdd_en);
  p_status_code_r10: assert property (@(posedge clk) disable iff (rst)
    seq_status <= 3'd4);
  p_vdd_from_idle_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(vdd_en) |-> $past(seq_status) == ST_IDLE);
  p_vdd_off_guard_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(vdd_en) |-> seq_status == ST_GUARD);
  p_down_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (seq_status == ST_RAMP_DN) |=> (seq_status != ST_ACTIVE && seq_status != ST_RAMP_UP));
  p_abort_r8: assert property (@(posedge clk) disable iff (rst)
    (seq_status == ST_RAMP_UP && !pwr_req) |=> seq_status == ST_RAMP_DN);
endmodule

bind pnl_seq_top pnl_seq_chk u_chk (
  .clk(clk), .rst(rst), .pwr_req(pwr_req), .vdd_en(vdd_en),
  .link_en(link_en), .bl_en(bl_en), .seq_status(seq_status)
);

// File: tb/sim_pnl_seq_top.sv
module sim_pnl_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int UNIT       = 50;
  localparam int LIMIT      = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic pwr_req = 1'b0;
  logic vdd_en, link_en, bl_en;
  logic [2:0] seq_status;

  int n_chk = 0;
  int n_err = 0;
  int div = 4;

  always #(CLK_PERIOD/2) clk = ~clk;

  pnl_seq_top #(.CYC_UNIT_TICKS(UNIT)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwr_req(pwr_req), .vdd_en(vdd_en), .link_en(link_en), .bl_en(bl_en),
    .seq_status(seq_status)
  );

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  function automatic logic sig_val(input int sel);
    case (sel)
      0: return vdd_en;
      1: return link_en;
      default: return bl_en;
    endcase
  endfunction

  task automatic wait_sig(input int sel, input logic lvl, output int n);
    n = 0;
    while (sig_val(sel) !== lvl && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic go_idle();
    int n;
    pwr_req = 1'b0;
    n = 0;
    while (seq_status != 3'd0 && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  // window for d ticks at the current divide count
  function automatic int lo_of(input int d); return (d - 1) * div; endfunction
  function automatic int hi_of(input int d); return d * div + 2; endfunction

  task automatic t_reset();
    chk_eq("R1 vdd", int'(vdd_en), 0);
    chk_eq("R1 link", int'(link_en), 0);
    chk_eq("R1 bl", int'(bl_en), 0);
    chk_eq("R1 status", int'(seq_status), 0);
  endtask

  task automatic t_power_on_off();
    int n;
    div = 4;
    wr(2'd2, 32'h0000_0401);            // div 4, guard v=1
    wr(2'd0, {16'd3, 16'd5});
    wr(2'd1, {16'd4, 16'd2});
    @(negedge clk);
    pwr_req = 1'b1;
    wait_sig(0, 1'b1, n);
    chk_eq("R4 link low at vdd rise", int'(link_en), 0);
    chk_eq("R10 status ramp up", int'(seq_status), 1);
    wait_sig(1, 1'b1, n);
    chk_rng("R2 R4 up delay", n, lo_of(3), hi_of(3));
    chk_eq("R4 bl low at link rise", int'(bl_en), 0);
    wait_sig(2, 1'b1, n);
    chk_rng("R2 R4 bl-on delay", n, lo_of(5), hi_of(5));
    chk_eq("R10 status on", int'(seq_status), 2);
    pwr_req = 1'b0;
    wait_sig(2, 1'b0, n);
    chk_eq("R5 link held at bl fall", int'(link_en), 1);
    chk_eq("R10 status ramp down", int'(seq_status), 3);
    wait_sig(1, 1'b0, n);
    chk_rng("R3 R5 bl-off delay", n, lo_of(2), hi_of(2));
    chk_eq("R5 vdd held at link fall", int'(vdd_en), 1);
    wait_sig(0, 1'b0, n);
    chk_rng("R3 R5 down delay", n, lo_of(4), hi_of(4));
    chk_eq("R6 status guard", int'(seq_status), 4);
    go_idle();
  endtask

  task automatic t_cycle_guard();
    int n;
    wr(2'd2, 32'h0000_0403);            // div 4, v=3 -> 2 units
    wr(2'd0, {16'd1, 16'd1});
    wr(2'd1, {16'd1, 16'd1});
    pwr_req = 1'b1;
    wait_sig(2, 1'b1, n);
    pwr_req = 1'b0;
    wait_sig(0, 1'b0, n);
    pwr_req = 1'b1;                     // request held off by guard
    wait_sig(0, 1'b1, n);
    chk_rng("R6 guard time v=3", n, (2*UNIT - 1) * div, 2*UNIT*div + 4);
    go_idle();
  endtask

  task automatic t_field_write();
    int n;
    wr(2'd2, 32'h0000_0403);
    wr(2'd3, 32'hFFFF_FFE1);            // only v=1 may land
    wr(2'd0, {16'd3, 16'd1});
    pwr_req = 1'b1;
    wait_sig(0, 1'b1, n);
    wait_sig(1, 1'b1, n);
    chk_rng("R7 divide count kept", n, lo_of(3), hi_of(3));
    wait_sig(2, 1'b1, n);
    pwr_req = 1'b0;
    wait_sig(0, 1'b0, n);
    pwr_req = 1'b1;
    wait_sig(0, 1'b1, n);
    chk_rng("R6 R7 guard v=1 no wait", n, 0, 4);
    go_idle();
  endtask

  task automatic t_abort();
    int n;
    int link_seen;
    wr(2'd0, {16'd20, 16'd30});
    wr(2'd1, {16'd3, 16'd3});
    pwr_req = 1'b1;
    wait_sig(0, 1'b1, n);
    @(negedge clk); @(negedge clk);
    pwr_req = 1'b0;
    @(negedge clk);
    chk_eq("R8 abort from supply phase", int'(seq_status), 3);
    link_seen = 0;
    n = 0;
    while (vdd_en && n < LIMIT) begin
      if (link_en) link_seen = 1;
      @(negedge clk);
      n++;
    end
    chk_eq("R8 link never raised", link_seen, 0);
    chk_rng("R8 down delay after abort", n, lo_of(3), hi_of(3) + 1);
    go_idle();
    wr(2'd0, {16'd1, 16'd30});
    pwr_req = 1'b1;
    wait_sig(1, 1'b1, n);
    @(negedge clk); @(negedge clk);
    pwr_req = 1'b0;
    @(negedge clk);
    chk_eq("R8 abort from link phase", int'(seq_status), 3);
    chk_eq("R8 bl stays low", int'(bl_en), 0);
    go_idle();
  endtask

  task automatic t_down_ignore();
    int n;
    int bad;
    wr(2'd0, {16'd1, 16'd1});
    wr(2'd1, {16'd10, 16'd10});
    pwr_req = 1'b1;
    wait_sig(2, 1'b1, n);
    pwr_req = 1'b0;
    wait_sig(2, 1'b0, n);
    @(negedge clk);
    pwr_req = 1'b1;
    bad = 0;
    n = 0;
    while (seq_status != 3'd4 && n < LIMIT) begin
      if (seq_status == 3'd1 || seq_status == 3'd2) bad = 1;
      @(negedge clk);
      n++;
    end
    chk_eq("R9 request ignored while down", bad, 0);
    chk_eq("R9 guard reached", int'(seq_status), 4);
    go_idle();
  endtask

  task automatic t_tick_zero();
    int n;
    div = 1;
    wr(2'd2, 32'h0000_0001);            // divide field 0 -> every clock
    wr(2'd0, {16'd10, 16'd1});
    pwr_req = 1'b1;
    wait_sig(0, 1'b1, n);
    wait_sig(1, 1'b1, n);
    chk_rng("R12 tick every clock", n, 9, 12);
    go_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_power_on_off();
    t_cycle_guard();
    t_field_write();
    t_abort();
    t_down_ignore();
    t_tick_zero();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule